// File: doc/BRIEF.md
# Size-Aware Add/Subtract Flag Unit

This block is the add/subtract arithmetic slice of a processor datapath. It takes a destination operand and a source operand, both 32 bits wide, together with an operation code, an operand size and the current condition-flag byte. It returns the arithmetic result, a write enable for the destination register, and a new flag byte.

The supported operations are add, add with carry, subtract, subtract with borrow, compare and negate. Each one works on byte, word or longword data. The half-carry flag follows the operand size: it comes from the carry or borrow out of the nibble just below the top nibble of the active size, not from the lowest nibble.

Outputs are registered. A request presented on the inputs before a rising clock edge appears on the outputs after that edge, so latency is one cycle and a new request can be accepted every cycle.

Top module: `addsub_flag_unit`

## Requirements
- R1: Add (op 0) outputs (dst + src) truncated to the active size. Add with carry (op 1) also adds flag bit 0. Flag C (bit 0) is the carry out of the active-size MSB.
- R2: Subtract (op 2) outputs (dst − src) at the active size. Subtract with borrow (op 3) also subtracts flag bit 0. For these operations, compare and negate, C is set exactly when a borrow occurs.
- R3: Flag H (bit 5) is the carry (for adds) or borrow (for subtracts) out of a size-dependent bit. That bit is 3 for byte (size 0), 11 for word (size 1) and 27 for longword (size 2 or 3).
- R4: Flag N (bit 3) equals the most significant bit of the result at the active size.
- R5: For op 0, 2, 4 and 5, flag Z (bit 2) is 1 when the active-size result is zero and 0 otherwise.
- R6: For op 1 and 3, Z is 1 only when the incoming Z was 1 and the result is zero. A nonzero result clears Z, and a zero result never sets it.
- R7: Flag V (bit 1) is 1 exactly when the signed two's-complement result at the active size overflows.
- R8: Compare (op 4) sets flags exactly as subtract does, but drives the write enable to 0. All other defined operations drive it to 1.
- R9: Negate (op 5) computes 0 − dst, with subtract flag rules. The source operand is ignored.
- R10: Flag bits 7, 6 and 4 are copied unchanged from the incoming flags.
- R11: Result bits above the active size are 0. Size 3 behaves as longword.
- R12: While reset is asserted (rst_n low), the result, write enable and flag outputs are all 0.
- R13: Op codes 6 and 7 give result 0 and write enable 0, and return the incoming flag byte unchanged.
- R14: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 compare, 5 negate) |
| size_i | input | 2 | Operand size (0 byte, 1 word, 2/3 longword) |
| dst_i | input | 32 | Destination (first) operand |
| src_i | input | 32 | Source (second) operand |
| flags_i | input | 8 | Incoming flag byte {I, UI, H, U, N, Z, V, C} |
| result_o | output | 32 | Registered result, zero above the active size |
| wr_en_o | output | 1 | Registered destination write enable |
| flags_o | output | 8 | Registered new flag byte |

## Verification
The unit holds no state beyond its output register. A wrong carry tap, a wrong size decode or a missing borrow inversion therefore shows up on result_o or flags_o on the very next cycle after the offending request. The bench compares all three outputs on every cycle against a behavioural integer model. The directed vectors put a carry or borrow across each of the nibble boundaries at bits 3, 11 and 27, and across each MSB. Chained-zero sequences and reserved opcodes are included, so that a fault in any single flag bit shows up within one cycle of the request that exposes it.

// File: rtl/asf_pkg.sv
package asf_pkg;

    localparam int ASF_W   = 32;
    localparam int FLAG_W  = 8;

    // flag byte bit positions (decoded by the surrounding core)
    localparam int FB_C  = 0;
    localparam int FB_V  = 1;
    localparam int FB_Z  = 2;
    localparam int FB_N  = 3;
    localparam int FB_U  = 4;
    localparam int FB_H  = 5;
    localparam int FB_UI = 6;
    localparam int FB_I  = 7;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_CMP  = 3'd4,
        OP_NEG  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } asf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } asf_size_e;

    typedef struct packed {
        logic [ASF_W-1:0]  result;
        logic              wr_en;
        logic [FLAG_W-1:0] flags;
    } asf_out_t;

endpackage

// File: rtl/asf_operand_prep.sv
module asf_operand_prep
    import asf_pkg::*;
#(
    parameter int W = 32
) (
    input  asf_op_e        op,
    input  logic [W-1:0]   dst,
    input  logic [W-1:0]   src,
    input  logic           c_in,
    output logic [W-1:0]   x,
    output logic [W-1:0]   y,
    output logic           cin,
    output logic           is_sub,
    output logic           known,
    output logic           chained
);

    always_comb begin
        x       = dst;
        y       = src;
        cin     = 1'b0;
        is_sub  = 1'b0;
        known   = 1'b1;
        chained = 1'b0;
        case (op)
            OP_ADD: begin
            end
            OP_ADDC: begin
                cin     = c_in;
                chained = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                y      = ~src;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            OP_SUBB: begin
                y       = ~src;
                cin     = ~c_in;
                is_sub  = 1'b1;
                chained = 1'b1;
            end
            OP_NEG: begin
                x      = '0;
                y      = ~dst;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/asf_carry_chain.sv
module asf_carry_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W:0]   cvec
);

    // cvec[k] is the carry into bit k; cvec[W] is the carry out of the top
    assign cvec[0] = cin;

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum[k]    = x[k] ^ y[k] ^ cvec[k];
        assign cvec[k+1] = (x[k] & y[k]) | (x[k] & cvec[k]) | (y[k] & cvec[k]);
    end

endmodule

// File: rtl/asf_flag_select.sv
module asf_flag_select
    import asf_pkg::*;
#(
    parameter int W = 32
) (
    input  asf_size_e     size,
    input  logic [W-1:0]  sum,
    input  logic [W:0]    cvec,
    input  logic          is_sub,
    output logic [W-1:0]  result,
    output logic          h_flag,
    output logic          n_flag,
    output logic          z_flag,
    output logic          v_flag,
    output logic          c_flag
);

    localparam int IDX_W  = $clog2(W + 1);
    localparam int MSB_B  = W / 4 - 1;
    localparam int MSB_WD = W / 2 - 1;
    localparam int MSB_L  = W - 1;
    localparam logic [W-1:0] MASK_B  = {{(W - W/4){1'b0}}, {(W/4){1'b1}}};
    localparam logic [W-1:0] MASK_WD = {{(W - W/2){1'b0}}, {(W/2){1'b1}}};
    localparam logic [W-1:0] MASK_L  = {W{1'b1}};

    logic [IDX_W-1:0] msb;
    logic [W-1:0]     mask;

    always_comb begin
        case (size)
            SZ_BYTE: begin
                msb  = IDX_W'(MSB_B);
                mask = MASK_B;
            end
            SZ_WORD: begin
                msb  = IDX_W'(MSB_WD);
                mask = MASK_WD;
            end
            default: begin
                msb  = IDX_W'(MSB_L);
                mask = MASK_L;
            end
        endcase
    end

    always_comb begin
        result = sum & mask;
        n_flag = sum[msb];
        z_flag = ~|result;
        // carry out of the top bit and out of the nibble below the top nibble
        c_flag = cvec[msb + IDX_W'(1)] ^ is_sub;
        h_flag = cvec[msb - IDX_W'(3)] ^ is_sub;
        v_flag = cvec[msb] ^ cvec[msb + IDX_W'(1)];
    end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
    import asf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_i,
    input  logic [1:0]  size_i,
    input  logic [31:0] dst_i,
    input  logic [31:0] src_i,
    input  logic [7:0]  flags_i,
    output logic [31:0] result_o,
    output logic        wr_en_o,
    output logic [7:0]  flags_o
);

    localparam int W = ASF_W;

    asf_op_e   op;
    asf_size_e size;
    logic [W-1:0] x, y, sum, res;
    logic [W:0]   cvec;
    logic cin, is_sub, known, chained;
    logic h_f, n_f, z_f, v_f, c_f;

    asf_out_t out_d, out_q;

    assign op   = asf_op_e'(op_i);
    assign size = asf_size_e'(size_i);

    asf_operand_prep #(.W(W)) u_prep (
        .op      (op),
        .dst     (dst_i),
        .src     (src_i),
        .c_in    (flags_i[FB_C]),
        .x       (x),
        .y       (y),
        .cin     (cin),
        .is_sub  (is_sub),
        .known   (known),
        .chained (chained)
    );

    asf_carry_chain #(.W(W)) u_chain (
        .x    (x),
        .y    (y),
        .cin  (cin),
        .sum  (sum),
        .cvec (cvec)
    );

    asf_flag_select #(.W(W)) u_flags (
        .size   (size),
        .sum    (sum),
        .cvec   (cvec),
        .is_sub (is_sub),
        .result (res),
        .h_flag (h_f),
        .n_flag (n_f),
        .z_flag (z_f),
        .v_flag (v_f),
        .c_flag (c_f)
    );

    always_comb begin
        out_d = '0;
        if (known) begin
            out_d.result    = res;
            out_d.wr_en     = (op != OP_CMP);
            out_d.flags     = flags_i;
            out_d.flags[FB_H] = h_f;
            out_d.flags[FB_N] = n_f;
            out_d.flags[FB_Z] = chained ? (z_f & flags_i[FB_Z]) : z_f;
            out_d.flags[FB_V] = v_f;
            out_d.flags[FB_C] = c_f;
        end else begin
            out_d.result = '0;
            out_d.wr_en  = 1'b0;
            out_d.flags  = flags_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign wr_en_o  = out_q.wr_en;
    assign flags_o  = out_q.flags;

endmodule

// File: rtl/asf_checker.sv
module asf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic [1:0]  size_i,
    input logic [7:0]  flags_i,
    input logic [31:0] result_o,
    input logic        wr_en_o,
    input logic [7:0]  flags_o
);

    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R12: assert (result_o == '0 && !wr_en_o && flags_o == '0);
        end
    end

    assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(op_i) == 3'd4) |-> !wr_en_o);

    assert_ctrl_bits_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (flags_o[7:6] == $past(flags_i[7:6]) && flags_o[4] == $past(flags_i[4])));

    assert_z_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && ($past(op_i) == 3'd1 || $past(op_i) == 3'd3) && !$past(flags_i[2]))
        |-> !flags_o[2]);

    assert_upper_zero_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(size_i) == 2'd0) |-> result_o[31:8] == '0);

    assert_n_is_msb_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(size_i) == 2'd1 && $past(op_i) < 3'd6) |-> flags_o[3] == result_o[15]);

    assert_z_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && ($past(op_i) == 3'd0 || $past(op_i) == 3'd2 || $past(op_i) == 3'd4
                       || $past(op_i) == 3'd5)) |-> flags_o[2] == (result_o == '0));

    assert_reserved_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(op_i) >= 3'd6) |-> (!wr_en_o && result_o == '0 && flags_o == $past(flags_i)));

endmodule

bind addsub_flag_unit asf_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .size_i   (size_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/sim_addsub_flag_unit.sv
module sim_addsub_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] src_i = '0;
    logic [7:0]  flags_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [7:0]  flags_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] q_res[$];
    logic        q_wen[$];
    logic [7:0]  q_flg[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    addsub_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .dst_i(dst_i), .src_i(src_i), .flags_i(flags_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic chk(input string req, input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    // behavioural reference model
    task automatic model(input int op, input int sz, input longint a, input longint b,
                         input logic [7:0] fin, output logic [31:0] res,
                         output logic wen, output logic [7:0] fout);
        int w;
        longint mask, half, hm, am, bm, x, y, cy, full, hfull, sx, sy, ss;
        logic h, n, z, v, c;
        w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        hm   = (longint'(1) << (w - 4)) - 1;
        am   = a & mask;
        bm   = b & mask;
        if (op >= 6) begin
            res = '0; wen = 1'b0; fout = fin;
            return;
        end
        if (op <= 1) begin
            cy    = (op == 1) ? longint'(fin[0]) : 0;
            full  = am + bm + cy;
            hfull = (am & hm) + (bm & hm) + cy;
            c = ((full >> w) & 1) != 0;
            h = ((hfull >> (w - 4)) & 1) != 0;
            sx = (am ^ half) - half;
            sy = (bm ^ half) - half;
            ss = sx + sy + cy;
        end else begin
            x = (op == 5) ? 0 : am;
            y = (op == 5) ? am : bm;
            cy    = (op == 3) ? longint'(fin[0]) : 0;
            full  = x - y - cy;
            hfull = (x & hm) - (y & hm) - cy;
            c = full < 0;
            h = hfull < 0;
            sx = (x ^ half) - half;
            sy = (y ^ half) - half;
            ss = sx - sy - cy;
        end
        v   = (ss >= half) || (ss < -half);
        res = 32'(full & mask);
        n   = ((full >> (w - 1)) & 1) != 0;
        z   = (res == 0);
        if (op == 1 || op == 3) z = z & fin[2];
        wen  = (op != 4);
        fout = {fin[7], fin[6], h, fin[4], n, z, v, c};
    endtask

    task automatic apply(input int op, input int sz, input logic [31:0] a,
                         input logic [31:0] b, input logic [7:0] fin, input string tag);
        logic [31:0] r; logic we; logic [7:0] f;
        op_i = 3'(op); size_i = 2'(sz); dst_i = a; src_i = b; flags_i = fin;
        model(op, sz, longint'(a), longint'(b), fin, r, we, f);
        q_res.push_back(r); q_wen.push_back(we); q_flg.push_back(f); q_tag.push_back(tag);
    endtask

    // compare one queued expectation at a falling edge (R14: one-cycle latency)
    task automatic compare_one();
        logic [31:0] r; logic we; logic [7:0] f; string t;
        if (q_res.size() == 0) return;
        r = q_res.pop_front(); we = q_wen.pop_front(); f = q_flg.pop_front(); t = q_tag.pop_front();
        chk("R1/R2/R9/R11/R14 result", t, result_o, r);
        chk("R8 wr_en", t, wr_en_o, we);
        chk("R3 H", t, flags_o[5], f[5]);
        chk("R4 N", t, flags_o[3], f[3]);
        chk("R5/R6 Z", t, flags_o[2], f[2]);
        chk("R7 V", t, flags_o[1], f[1]);
        chk("R2 C", t, flags_o[0], f[0]);
        chk("R10/R13 ctrl", t, {flags_o[7:6], flags_o[4]}, {f[7:6], f[4]});
    endtask

    task automatic step(input int op, input int sz, input logic [31:0] a,
                        input logic [31:0] b, input logic [7:0] fin, input string tag);
        @(negedge clk);
        compare_one();
        apply(op, sz, a, b, fin, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset result", "reset", result_o, 0);
        chk("R12 reset wr_en", "reset", wr_en_o, 0);
        chk("R12 reset flags", "reset", flags_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 32'h0F, 32'h01, 8'h00, "R3 byte nibble carry");
        step(0, 1, 32'h0FFF, 32'h0001, 8'h00, "R3 word bit11 carry");
        step(0, 2, 32'h0FFF_FFFF, 32'h1, 8'h00, "R3 long bit27 carry");
        step(0, 1, 32'h000F, 32'h0001, 8'h00, "R3 word low nibble no H");
        step(0, 0, 32'h7F, 32'h01, 8'h00, "R7 byte overflow R4");
        step(0, 0, 32'hFF, 32'h01, 8'h00, "R1 carry R5 zero");
        step(0, 0, 32'hAB12_34FF, 32'hCD00_0001, 8'h00, "R11 upper bits dropped");
        step(2, 0, 32'h00, 32'h01, 8'h00, "R2 byte borrow");
        step(2, 2, 32'h1000_0000, 32'h1, 8'h00, "R3 long bit27 borrow");
        step(2, 2, 32'h8000_0000, 32'h1, 8'h00, "R7 long sub overflow");
        step(4, 1, 32'h1234, 32'h1234, 8'h00, "R8 compare equal");
        step(5, 0, 32'h80, 32'h55, 8'h00, "R9 negate min byte");
        step(5, 1, 32'h0000, 32'hFFFF, 8'h00, "R9 negate zero");
        step(1, 0, 32'hFF, 32'h00, 8'h05, "R6 addc zero keeps Z");
        step(1, 0, 32'hFF, 32'h00, 8'h01, "R6 addc zero no set Z");
        step(3, 1, 32'h0001, 32'h0000, 8'h05, "R6 subb zero keeps Z");
        step(3, 1, 32'h0005, 32'h0001, 8'h05, "R6 subb nonzero clears Z");
        step(0, 3, 32'hFFFF_FFFF, 32'h1, 8'hD0, "R11 size3 as long R10");
        step(6, 0, 32'h1, 32'h2, 8'hA7, "R13 reserved 6");
        step(7, 2, 32'h3, 32'h4, 8'h5A, "R13 reserved 7");
        for (int i = 0; i < 3000; i++) begin
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                 $urandom(), $urandom(), 8'($urandom()), "random");
        end
        @(negedge clk);
        compare_one();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule